// File: doc/BRIEF.md
# Tagged Request Hub with Response Routing

This block sits between a fixed set of requesting clients and one shared server. Every client presents requests on its own valid/ready port. The hub merges them into a single request stream toward the server, choosing among the clients in round-robin order. Each forwarded request carries a tag that holds the index of the client that issued it.

The server answers with a response plus a tag. It must return the same tag that it received with the request. The hub drops the tag and writes the response into a small queue that belongs to the client the tag names. Each client drains its own queue through its response port. A tag that names no client is accepted and thrown away, and a sticky error output records the event.

The number of clients, the payload widths and the queue depth are build-time parameters. The tag is one bit wider than needed whenever that is the only way to make invalid codes possible, so an out-of-range tag can always be expressed.

Top module: `hub_srv`

## Requirements
- R1: After reset, srv_req_valid_o, every cli_req_ready_o bit, every cli_rsp_valid_o bit and bad_tag_o are 0 while no input is active.
- R2: srv_req_valid_o is high exactly when at least one client asserts a request. srv_req_data_o then equals the granted client's data, and srv_req_tag_o equals that client's index (client i uses tag value i).
- R3: At most one cli_req_ready_o bit is high. It is the granted client's bit, and it is high only while srv_req_ready_i is high.
- R4: Grant is round-robin. After reset the search starts at client 0. After a handshake by client k, the search starts at client k+1, wrapping to 0 after N_CLIENTS-1, and the grant goes to the first requesting client found.
- R5: A response accepted with tag t < N_CLIENTS is placed only in client t's queue. It can appear on cli_rsp_valid_o[t] in the cycle after acceptance.
- R6: Each client receives its responses in the order the server delivered them.
- R7: For a tag t < N_CLIENTS, srv_rsp_ready_o is high exactly when client t's queue holds fewer than RSP_DEPTH entries. A queue pops when cli_rsp_valid_o and cli_rsp_ready_i are both high.
- R8: A response whose tag is N_CLIENTS or more is always accepted (srv_rsp_ready_o high) and reaches no client queue. bad_tag_o goes high in the following cycle and stays high until reset.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cli_req_valid_i | input | N_CLIENTS | Per-client request valid |
| cli_req_ready_o | output | N_CLIENTS | Per-client request ready |
| cli_req_data_i | input | N_CLIENTS x REQ_W | Per-client request payload |
| srv_req_valid_o | output | 1 | Merged request valid |
| srv_req_ready_i | input | 1 | Server ready for a request |
| srv_req_data_o | output | REQ_W | Merged request payload |
| srv_req_tag_o | output | TagW | Index of the issuing client |
| srv_rsp_valid_i | input | 1 | Server response valid |
| srv_rsp_ready_o | output | 1 | Hub ready for the response |
| srv_rsp_data_i | input | RSP_W | Response payload |
| srv_rsp_tag_i | input | TagW | Tag returned by the server |
| cli_rsp_valid_o | output | N_CLIENTS | Per-client response valid |
| cli_rsp_ready_i | input | N_CLIENTS | Per-client response ready |
| cli_rsp_data_o | output | N_CLIENTS x RSP_W | Per-client response payload |
| bad_tag_o | output | 1 | Sticky flag for an out-of-range response tag |

## Verification
The bench builds the hub with three clients and a queue depth of 4. Three clients is not a power of two, so the 2-bit tag has one unused code (3), and the drop path and the sticky flag can be reached by random tags. A short depth makes full queues and back-pressure on srv_rsp_ready_o frequent, and a phase in which clients rarely drain keeps queues full for long stretches. The odd client count also exercises the wrap of the round-robin pointer from index 2 back to 0.

// File: rtl/hub_pkg.sv
package hub_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hub_rr_arb.sv
module hub_rr_arb #(
  parameter int unsigned N = 3,
  localparam int unsigned IdxW = hub_pkg::idx_w(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic            adv_i,
  output logic [N-1:0]    gnt_o,
  output logic [IdxW-1:0] gnt_idx_o,
  output logic            any_o
);
  logic [IdxW-1:0] ptr_q;

  // first requester at or after ptr_q, wrapping
  always_comb begin
    int c;
    gnt_o     = '0;
    gnt_idx_o = '0;
    any_o     = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      c = (int'(ptr_q) + k) % int'(N);
      if (!any_o && req_i[c]) begin
        any_o     = 1'b1;
        gnt_o[c]  = 1'b1;
        gnt_idx_o = IdxW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv_i && any_o) begin
      ptr_q <= (gnt_idx_o == IdxW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/hub_req_merge.sv
module hub_req_merge #(
  parameter int unsigned N    = 3,
  parameter int unsigned W    = 16,
  parameter int unsigned TagW = 2,
  localparam int unsigned IdxW = hub_pkg::idx_w(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        valid_i,
  output logic [N-1:0]        ready_o,
  input  logic [N-1:0][W-1:0] data_i,
  output logic                srv_valid_o,
  input  logic                srv_ready_i,
  output logic [W-1:0]        srv_data_o,
  output logic [TagW-1:0]     srv_tag_o
);
  logic [N-1:0]    gnt;
  logic [IdxW-1:0] gnt_idx;
  logic            any;

  hub_rr_arb #(.N(N)) arb_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (valid_i),
    .adv_i    (srv_ready_i),
    .gnt_o    (gnt),
    .gnt_idx_o(gnt_idx),
    .any_o    (any)
  );

  always_comb begin
    srv_data_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (gnt[i]) srv_data_o = data_i[i];
    end
  end

  assign srv_valid_o = any;
  assign srv_tag_o   = TagW'(gnt_idx);
  assign ready_o     = srv_ready_i ? gnt : '0;
endmodule

// File: rtl/hub_rsp_fifo.sv
module hub_rsp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PtrW = hub_pkg::idx_w(DEPTH),
  localparam int unsigned CntW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic         valid_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0]    mem_q [DEPTH];
  logic [PtrW-1:0] wr_q, rd_q;
  logic [CntW-1:0] cnt_q;
  logic            do_push, do_pop;

  assign ready_o = (cnt_q != CntW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && ready_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PtrW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PtrW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/hub_rsp_route.sv
module hub_rsp_route #(
  parameter int unsigned N    = 3,
  parameter int unsigned TagW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [TagW-1:0] tag_i,
  input  logic [N-1:0]    q_ready_i,
  output logic [N-1:0]    push_o,
  output logic            ready_o,
  output logic            bad_o
);
  logic in_range, sel_ready, bad_q;

  assign in_range = (int'(tag_i) < int'(N));

  always_comb begin
    sel_ready = 1'b0;
    push_o    = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (tag_i == TagW'(i)) begin
        sel_ready = q_ready_i[i];
        push_o[i] = valid_i;
      end
    end
  end

  // unknown tags are swallowed so the server never stalls on them
  assign ready_o = in_range ? sel_ready : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    bad_q <= 1'b0;
    else if (valid_i && !in_range)  bad_q <= 1'b1;
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/hub_srv.sv
module hub_srv #(
  parameter int unsigned N_CLIENTS = 3,
  parameter int unsigned REQ_W     = 16,
  parameter int unsigned RSP_W     = 16,
  parameter int unsigned RSP_DEPTH = 4,
  localparam int unsigned TagW = $clog2(N_CLIENTS + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_CLIENTS-1:0]            cli_req_valid_i,
  output logic [N_CLIENTS-1:0]            cli_req_ready_o,
  input  logic [N_CLIENTS-1:0][REQ_W-1:0] cli_req_data_i,
  output logic                            srv_req_valid_o,
  input  logic                            srv_req_ready_i,
  output logic [REQ_W-1:0]                srv_req_data_o,
  output logic [TagW-1:0]                 srv_req_tag_o,
  input  logic                            srv_rsp_valid_i,
  output logic                            srv_rsp_ready_o,
  input  logic [RSP_W-1:0]                srv_rsp_data_i,
  input  logic [TagW-1:0]                 srv_rsp_tag_i,
  output logic [N_CLIENTS-1:0]            cli_rsp_valid_o,
  input  logic [N_CLIENTS-1:0]            cli_rsp_ready_i,
  output logic [N_CLIENTS-1:0][RSP_W-1:0] cli_rsp_data_o,
  output logic                            bad_tag_o
);
  logic [N_CLIENTS-1:0] q_ready, q_push;

  hub_req_merge #(.N(N_CLIENTS), .W(REQ_W), .TagW(TagW)) merge_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (cli_req_valid_i),
    .ready_o    (cli_req_ready_o),
    .data_i     (cli_req_data_i),
    .srv_valid_o(srv_req_valid_o),
    .srv_ready_i(srv_req_ready_i),
    .srv_data_o (srv_req_data_o),
    .srv_tag_o  (srv_req_tag_o)
  );

  hub_rsp_route #(.N(N_CLIENTS), .TagW(TagW)) route_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (srv_rsp_valid_i),
    .tag_i    (srv_rsp_tag_i),
    .q_ready_i(q_ready),
    .push_o   (q_push),
    .ready_o  (srv_rsp_ready_o),
    .bad_o    (bad_tag_o)
  );

  for (genvar g = 0; g < int'(N_CLIENTS); g++) begin : g_cli_q
    hub_rsp_fifo #(.W(RSP_W), .DEPTH(RSP_DEPTH)) fifo_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (q_push[g]),
      .data_i (srv_rsp_data_i),
      .ready_o(q_ready[g]),
      .valid_o(cli_rsp_valid_o[g]),
      .pop_i  (cli_rsp_ready_i[g]),
      .data_o (cli_rsp_data_o[g])
    );
  end
endmodule

// File: rtl/hub_srv_chk.sv
module hub_srv_chk #(
  parameter int unsigned N_CLIENTS = 3,
  localparam int unsigned TagW = $clog2(N_CLIENTS + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_CLIENTS-1:0] cli_req_valid_i,
  input logic [N_CLIENTS-1:0] cli_req_ready_o,
  input logic                 srv_req_valid_o,
  input logic                 srv_req_ready_i,
  input logic [TagW-1:0]      srv_req_tag_o,
  input logic                 srv_rsp_valid_i,
  input logic                 srv_rsp_ready_o,
  input logic [TagW-1:0]      srv_rsp_tag_i,
  input logic [N_CLIENTS-1:0] cli_rsp_valid_o,
  input logic                 bad_tag_o
);
  a_r2_tag_names_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srv_req_valid_o |-> (int'(srv_req_tag_o) < int'(N_CLIENTS)) &&
                        cli_req_valid_i[srv_req_tag_o]);

  a_r2_valid_when_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cli_req_valid_i) |-> srv_req_valid_o);

  a_r3_single_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cli_req_ready_o));

  a_r3_ready_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cli_req_ready_o) |-> srv_req_ready_i && srv_req_valid_o);

  a_r8_bad_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srv_rsp_valid_i && int'(srv_rsp_tag_i) >= int'(N_CLIENTS)) |-> srv_rsp_ready_o);

  a_r8_bad_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srv_rsp_valid_i && int'(srv_rsp_tag_i) >= int'(N_CLIENTS)) |=> bad_tag_o);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_tag_o |=> bad_tag_o);

  for (genvar g = 0; g < int'(N_CLIENTS); g++) begin : g_cli
    a_r5_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srv_rsp_valid_i && srv_rsp_ready_o && srv_rsp_tag_i == TagW'(g))
        |=> cli_rsp_valid_o[g]);
  end
endmodule

bind hub_srv hub_srv_chk #(.N_CLIENTS(N_CLIENTS)) chk_i (.*);

// File: tb/hub_srv_tb_top.sv
`timescale 1ns/1ps
module hub_srv_tb_top;
  localparam int N = 3;
  localparam int REQ_W = 16;
  localparam int RSP_W = 16;
  localparam int DEPTH = 4;
  localparam int TagW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cli_req_valid, cli_req_ready, cli_rsp_valid, cli_rsp_ready;
  logic [N-1:0][REQ_W-1:0] cli_req_data;
  logic [N-1:0][RSP_W-1:0] cli_rsp_data;
  logic srv_req_valid, srv_req_ready, srv_rsp_valid, srv_rsp_ready, bad_tag;
  logic [REQ_W-1:0] srv_req_data;
  logic [RSP_W-1:0] srv_rsp_data;
  logic [TagW-1:0] srv_req_tag, srv_rsp_tag;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_ptr;
  bit m_bad;
  logic [RSP_W-1:0] mq [N][$];

  always #10 clk = ~clk;

  hub_srv #(.N_CLIENTS(N), .REQ_W(REQ_W), .RSP_W(RSP_W), .RSP_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cli_req_valid_i(cli_req_valid), .cli_req_ready_o(cli_req_ready),
    .cli_req_data_i(cli_req_data),
    .srv_req_valid_o(srv_req_valid), .srv_req_ready_i(srv_req_ready),
    .srv_req_data_o(srv_req_data), .srv_req_tag_o(srv_req_tag),
    .srv_rsp_valid_i(srv_rsp_valid), .srv_rsp_ready_o(srv_rsp_ready),
    .srv_rsp_data_i(srv_rsp_data), .srv_rsp_tag_i(srv_rsp_tag),
    .cli_rsp_valid_o(cli_rsp_valid), .cli_rsp_ready_i(cli_rsp_ready),
    .cli_rsp_data_o(cli_rsp_data), .bad_tag_o(bad_tag)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_grant(logic [N-1:0] v, int ptr);
    for (int k = 0; k < N; k++) if (v[(ptr + k) % N]) return (ptr + k) % N;
    return -1;
  endfunction

  function automatic logic exp_rsp_ready(logic [TagW-1:0] t);
    if (int'(t) >= N) return 1'b1;
    return mq[int'(t)].size() < DEPTH;
  endfunction

  task automatic idle_inputs();
    cli_req_valid = '0; cli_req_data = '0; cli_rsp_ready = '0;
    srv_req_ready = 1'b0; srv_rsp_valid = 1'b0; srv_rsp_data = '0; srv_rsp_tag = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_ptr = 0; m_bad = 0;
    for (int i = 0; i < N; i++) mq[i].delete();
    #2;
    chk("R1 srv_req_valid", srv_req_valid, 0);
    chk("R1 cli_req_ready", cli_req_ready, 0);
    chk("R1 cli_rsp_valid", cli_rsp_valid, 0);
    chk("R1 bad_tag", bad_tag, 0);
  endtask

  // one cycle: drive at negedge, check settled outputs, advance model
  task automatic step(int p_req, int p_srv, int p_rsp, int p_drain, int p_bad);
    int g;
    logic push_ok;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cli_req_valid[i] = ($urandom_range(99) < p_req);
      cli_req_data[i]  = REQ_W'($urandom);
      cli_rsp_ready[i] = ($urandom_range(99) < p_drain);
    end
    srv_req_ready = ($urandom_range(99) < p_srv);
    srv_rsp_valid = ($urandom_range(99) < p_rsp);
    srv_rsp_data  = RSP_W'($urandom);
    srv_rsp_tag   = ($urandom_range(99) < p_bad) ? TagW'(N) : TagW'($urandom_range(N - 1));
    #2;
    g = exp_grant(cli_req_valid, m_ptr);
    chk("R2 srv_req_valid", srv_req_valid, g >= 0);
    if (g >= 0) begin
      chk("R4 grant tag", srv_req_tag, g);
      chk("R2 srv_req_data", srv_req_data, cli_req_data[g]);
    end
    chk("R3 cli_req_ready", cli_req_ready,
        (g >= 0 && srv_req_ready) ? (N'(1) << g) : '0);
    for (int i = 0; i < N; i++) begin
      chk("R5 cli_rsp_valid", cli_rsp_valid[i], mq[i].size() > 0);
      if (mq[i].size() > 0) chk("R6 cli_rsp_data order", cli_rsp_data[i], mq[i][0]);
    end
    if (srv_rsp_valid) chk("R7 srv_rsp_ready", srv_rsp_ready, exp_rsp_ready(srv_rsp_tag));
    chk("R8 bad_tag", bad_tag, m_bad);
    // model update at the coming edge
    if (g >= 0 && srv_req_ready) m_ptr = (g + 1) % N;
    push_ok = srv_rsp_valid && int'(srv_rsp_tag) < N && mq[int'(srv_rsp_tag)].size() < DEPTH;
    for (int i = 0; i < N; i++)
      if (cli_rsp_ready[i] && mq[i].size() > 0) void'(mq[i].pop_front());
    if (push_ok) mq[int'(srv_rsp_tag)].push_back(srv_rsp_data);
    if (srv_rsp_valid && int'(srv_rsp_tag) >= N) m_bad = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // queues fill and stall, no bad tags yet
    repeat (300) step(70, 60, 80, 10, 0);
    chk("R8 flag still low", bad_tag, 0);
    // all clients always requesting: rotation with wrap
    repeat (200) step(100, 50, 50, 50, 0);
    // full mix including out-of-range tags
    repeat (2000) step(50, 70, 60, 60, 15);
    chk("R8 flag sticky", bad_tag, 1);
    do_reset();
    repeat (500) step(60, 60, 60, 40, 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule